// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Bank

This block holds four independent 32-bit timers behind a plain memory-mapped register port. Each timer counts down from a programmable reload value, one step per clock, while both a bank-wide enable and its own enable are set. When a timer has sat at zero for a tick, it reloads, bumps a 32-bit wrap counter and raises an interrupt status bit. A per-channel mask decides whether that status reaches the channel's interrupt pin.

Software that wants a 64-bit time base reads the wrap counter first. That read also latches the live counter into a per-channel snapshot register. The later read of the counter register returns the snapshot, so the two words always describe the same clock edge. A reload of all ones gives a free-running full-range counter, and inverting it bitwise turns it into an up-count.

The register port has no back-pressure and no valid/ready handshake. A write completes on the clock edge where `wr_en` is high. For a read, the address is presented with `rd_en` high, and `rdata` holds the result from the next clock edge until the next read.

Top module: `tmr_bank`

## Requirements
- R1: Bank control sits at byte offset 0x00, and its bit 0 is the bank enable (reset 0, readable back). A read-only revision word at offset 0x10 returns the parameter `REV`, which defaults to 0x0001_0000.
- R2: Channel n (0 to 3) occupies the window starting at 0x20 + 0x20*n. Within that window the offsets are: 0x00 enable (bit 0), 0x04 reload, 0x08 counter, 0x0C wrap count, 0x10 status (bit 0), 0x14 clear (write-only), 0x18 mask (bit 0). Read data appears on `rdata` one clock after `rd_en`.
- R3: A channel's counter changes only while both the bank enable and its own enable are 1. Otherwise it holds its value.
- R4: While running, the counter decrements once per clock. On the tick after it reads zero, it loads the reload value, the wrap count increments by one and status bit 0 is set. The period is therefore reload+1 clocks. A reload of 0 wraps on every tick, and a reload of 0xFFFFFFFF runs the full 32-bit range.
- R5: A read of a channel's wrap-count register copies that channel's counter into its snapshot. Reads of the counter register return the snapshot, which stays unchanged until the next wrap-count read.
- R6: A write that sets a channel's enable while the enable is 0 loads the counter with the reload value. A write of 1 while the enable is already 1 leaves the counter alone.
- R7: `irq[n]` is status AND mask of channel n. With the mask at 0 the pin stays low, but status still gets set.
- R8: A write with bit 0 set to a channel's clear register clears that channel's status bit.
- R9: Reads of unmapped offsets return zero. Writes to the revision, counter, wrap-count and status registers have no effect.
- R10: After reset, every enable, counter, wrap count, snapshot, status bit and mask bit is 0, and every reload register holds 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the count tick |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Byte address of the access |
| wr_en | input | 1 | Write strobe, acts on the rising edge |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; result appears on `rdata` next clock |
| rdata | output | 32 | Registered read data |
| irq | output | 4 | Per-channel interrupt, status AND mask |

## Verification
The bench targets the snapshot ordering. It reads the counter, lets the channel run, and reads the counter again without an intervening wrap-count read; a design that returned the live value would report a moved counter. It drives a reload of zero, which a design that decremented before testing for zero would turn into an underflow to all ones instead of a wrap on every tick. It also checks that re-writing an enable that is already set does not restart the count, that a masked channel still records status without raising its pin, and that unmapped and read-only locations neither return stale data nor accept writes.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;
  localparam int LOC_W = 5;

  // bank-wide offsets
  localparam logic [LOC_W-1:0] G_CTRL = 5'h00;
  localparam logic [LOC_W-1:0] G_REV  = 5'h10;

  // offsets inside one channel window
  localparam logic [LOC_W-1:0] L_CFG    = 5'h00;
  localparam logic [LOC_W-1:0] L_RELOAD = 5'h04;
  localparam logic [LOC_W-1:0] L_CUR    = 5'h08;
  localparam logic [LOC_W-1:0] L_WRAP   = 5'h0C;
  localparam logic [LOC_W-1:0] L_STS    = 5'h10;
  localparam logic [LOC_W-1:0] L_CLR    = 5'h14;
  localparam logic [LOC_W-1:0] L_MSK    = 5'h18;
endpackage

// File: rtl/tmr_bank_dec.sv
module tmr_bank_dec
  import tmr_bank_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 8
) (
  input  logic [AW-1:0]    addr,
  output logic             is_glb,
  output logic [NCH-1:0]   ch_sel,
  output logic [LOC_W-1:0] loc,
  output logic             mapped
);
  localparam int RW = AW - LOC_W;

  logic [RW-1:0] region;
  logic          loc_glb_ok;
  logic          loc_ch_ok;

  assign region = addr[AW-1:LOC_W];
  assign loc    = addr[LOC_W-1:0];
  assign is_glb = (region == '0);

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_sel
      localparam logic [RW-1:0] IDX = RW'(i + 1);
      assign ch_sel[i] = (region == IDX);
    end
  endgenerate

  always_comb begin
    loc_glb_ok = (loc == G_CTRL) || (loc == G_REV);
    case (loc)
      L_CFG, L_RELOAD, L_CUR, L_WRAP, L_STS, L_CLR, L_MSK: loc_ch_ok = 1'b1;
      default:                                              loc_ch_ok = 1'b0;
    endcase
    mapped = is_glb ? loc_glb_ok : ((|ch_sel) && loc_ch_ok);
  end
endmodule

// File: rtl/tmr_bank_chan.sv
module tmr_bank_chan
  import tmr_bank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_en,
  input  logic             sel,
  input  logic             we,
  input  logic             re,
  input  logic [LOC_W-1:0] loc,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rd_val,
  output logic             irq
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic          en_q, msk_q, sts_q;
  logic [DW-1:0] rld_q, cnt_q, wrap_q, snap_q;
  logic          wr_hit, rd_hit, ld, run, wrap_evt, snap_evt;

  assign wr_hit   = sel && we;
  assign rd_hit   = sel && re;
  assign ld       = wr_hit && (loc == L_CFG) && wdata[0] && !en_q;
  assign run      = glb_en && en_q;
  assign wrap_evt = run && !ld && (cnt_q == '0);
  assign snap_evt = rd_hit && (loc == L_WRAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      msk_q  <= 1'b0;
      sts_q  <= 1'b0;
      rld_q  <= '1;
      cnt_q  <= '0;
      wrap_q <= '0;
      snap_q <= '0;
    end else begin
      if (wr_hit && loc == L_CFG)    en_q  <= wdata[0];
      if (wr_hit && loc == L_RELOAD) rld_q <= wdata;
      if (wr_hit && loc == L_MSK)    msk_q <= wdata[0];

      if (ld)
        cnt_q <= rld_q;
      else if (run)
        cnt_q <= (cnt_q == '0) ? rld_q : cnt_q - ONE;

      if (wrap_evt) wrap_q <= wrap_q + ONE;

      if (wrap_evt)
        sts_q <= 1'b1;
      else if (wr_hit && loc == L_CLR && wdata[0])
        sts_q <= 1'b0;

      if (snap_evt) snap_q <= cnt_q;
    end
  end

  always_comb begin
    rd_val = '0;
    if (sel) begin
      case (loc)
        L_CFG:    rd_val = {{(DW-1){1'b0}}, en_q};
        L_RELOAD: rd_val = rld_q;
        L_CUR:    rd_val = snap_q;
        L_WRAP:   rd_val = wrap_q;
        L_STS:    rd_val = {{(DW-1){1'b0}}, sts_q};
        L_MSK:    rd_val = {{(DW-1){1'b0}}, msk_q};
        default:  rd_val = '0;
      endcase
    end
  end

  assign irq = sts_q && msk_q;

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld) |=> $stable(cnt_q));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt_q == $past(rld_q)) && sts_q && (wrap_q == $past(wrap_q) + ONE));

  assert_snap_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_evt |=> $stable(snap_q));

  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt_q == $past(rld_q)) && en_q);

  assert_irq_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !msk_q |-> !irq);
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_bank_pkg::*;
#(
  parameter int          NCH = 4,
  parameter int          DW  = 32,
  parameter int          AW  = 8,
  parameter logic [31:0] REV = 32'h0001_0000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr,
  input  logic           wr_en,
  input  logic [DW-1:0]  wdata,
  input  logic           rd_en,
  output logic [DW-1:0]  rdata,
  output logic [NCH-1:0] irq
);
  logic             glb_q;
  logic             is_glb, mapped;
  logic [NCH-1:0]   ch_sel;
  logic [LOC_W-1:0] loc;
  logic [DW-1:0]    ch_rd [NCH];
  logic [DW-1:0]    g_val, rd_mux;

  tmr_bank_dec #(.NCH(NCH), .AW(AW)) u_dec (
    .addr   (addr),
    .is_glb (is_glb),
    .ch_sel (ch_sel),
    .loc    (loc),
    .mapped (mapped)
  );

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_ch
      tmr_bank_chan #(.DW(DW)) u_ch (
        .clk    (clk),
        .rst_n  (rst_n),
        .glb_en (glb_q),
        .sel    (ch_sel[i]),
        .we     (wr_en),
        .re     (rd_en),
        .loc    (loc),
        .wdata  (wdata),
        .rd_val (ch_rd[i]),
        .irq    (irq[i])
      );
    end
  endgenerate

  always_comb begin
    g_val = '0;
    if (is_glb) begin
      if (loc == G_CTRL)     g_val = {{(DW-1){1'b0}}, glb_q};
      else if (loc == G_REV) g_val = DW'(REV);
    end
    rd_mux = g_val;
    for (int k = 0; k < NCH; k++) rd_mux = rd_mux | ch_rd[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glb_q <= 1'b0;
      rdata <= '0;
    end else begin
      if (wr_en && is_glb && loc == G_CTRL) glb_q <= wdata[0];
      if (rd_en) rdata <= rd_mux;
    end
  end

  assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |=> (rdata == '0));

  assert_rev_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && is_glb && loc == G_REV) |=> (rdata == DW'(REV)));
endmodule

// File: tb/sim_tmr_bank.sv
module sim_tmr_bank;
  localparam logic [31:0] REV_EXP = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  tmr_bank u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .irq(irq)
  );

  function automatic logic [7:0] cb(input int ch, input logic [7:0] off);
    return 8'(8'h20 + 8'h20 * ch) + off;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // bank enable on for k idle clocks: k+1 running edges
  task automatic burst(input int k);
    wr(8'h00, 32'd1);
    repeat (k) @(negedge clk);
    wr(8'h00, 32'd0);
  endtask

  // reference model of one channel over n running edges
  task automatic model(input logic [31:0] rld, input int n,
                       inout logic [31:0] c, inout logic [31:0] w);
    for (int e = 0; e < n; e++) begin
      if (c == 0) begin c = rld; w = w + 1; end
      else c = c - 1;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v);          chk("R10 bank enable", v, 0);
    for (int ch = 0; ch < 4; ch++) begin
      rd(cb(ch, 8'h04), v); chk("R10 reload", v, 32'hFFFF_FFFF);
      rd(cb(ch, 8'h0C), v); chk("R10 wrap count", v, 0);
      rd(cb(ch, 8'h08), v); chk("R10 counter", v, 0);
      rd(cb(ch, 8'h10), v); chk("R10 status", v, 0);
    end
    rd(cb(0, 8'h18), v);   chk("R10 mask", v, 0);
    chk("R10 irq", {28'd0, irq}, 0);
  endtask

  task automatic t_count();
    logic [31:0] v, c, w;
    wr(cb(1, 8'h04), 32'd5);
    rd(cb(1, 8'h04), v);   chk("R2 reload readback", v, 5);
    wr(cb(1, 8'h00), 32'd1);
    c = 5; w = 0;
    burst(8); model(32'd5, 9, c, w);
    rd(cb(1, 8'h0C), v);   chk("R4 wrap count", v, w);
    rd(cb(1, 8'h08), v);   chk("R4 counter", v, c);
    rd(cb(1, 8'h10), v);   chk("R4 status set", v, 1);
    chk("R7 masked irq low", {28'd0, irq}, 0);
    wr(cb(1, 8'h18), 32'd1);
    chk("R7 irq raised", {28'd0, irq}, 32'h2);
    wr(cb(1, 8'h14), 32'd1);
    rd(cb(1, 8'h10), v);   chk("R8 status cleared", v, 0);
    chk("R8 irq dropped", {28'd0, irq}, 0);
    wr(cb(1, 8'h00), 32'd0);
  endtask

  task automatic t_gate();
    logic [31:0] v, c, w;
    wr(cb(2, 8'h04), 32'd3);
    wr(cb(2, 8'h00), 32'd1);
    repeat (10) @(negedge clk);
    rd(cb(2, 8'h0C), v);   chk("R3 no wrap with bank off", v, 0);
    rd(cb(2, 8'h08), v);   chk("R3 hold with bank off", v, 3);
    c = 3; w = 0;
    burst(4); model(32'd3, 5, c, w);
    rd(cb(2, 8'h0C), v);   chk("R3 ch2 wraps", v, w);
    rd(cb(2, 8'h08), v);   chk("R3 ch2 counter", v, c);
    rd(cb(1, 8'h0C), v);   chk("R3 ch1 wrap frozen", v, 1);
    rd(cb(1, 8'h08), v);   chk("R3 ch1 counter frozen", v, 2);
  endtask

  task automatic t_snap();
    logic [31:0] v, c, w, c0;
    c = 2; w = 1;  // ch2 state after t_gate
    rd(cb(2, 8'h0C), v);
    rd(cb(2, 8'h08), c0);  chk("R5 first snapshot", c0, c);
    burst(2); model(32'd3, 3, c, w);
    rd(cb(2, 8'h08), v);   chk("R5 snapshot held", v, c0);
    rd(cb(2, 8'h0C), v);   chk("R5 wrap count", v, w);
    rd(cb(2, 8'h08), v);   chk("R5 snapshot refreshed", v, c);
  endtask

  task automatic t_reenable();
    logic [31:0] v;
    wr(cb(2, 8'h00), 32'd0);
    wr(cb(2, 8'h04), 32'h10);
    wr(cb(2, 8'h00), 32'd1);
    rd(cb(2, 8'h0C), v);
    rd(cb(2, 8'h08), v);   chk("R6 load on enable", v, 32'h10);
    burst(1);
    wr(cb(2, 8'h00), 32'd1);
    rd(cb(2, 8'h0C), v);
    rd(cb(2, 8'h08), v);   chk("R6 no reload when already on", v, 32'h0E);
    wr(cb(2, 8'h00), 32'd0);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    wr(cb(0, 8'h04), 32'd0);
    wr(cb(0, 8'h00), 32'd1);
    burst(3);
    rd(cb(0, 8'h0C), v);   chk("R4 zero reload wraps every tick", v, 4);
    rd(cb(0, 8'h08), v);   chk("R4 zero reload counter", v, 0);
    wr(cb(0, 8'h00), 32'd0);
  endtask

  task automatic t_free();
    logic [31:0] v;
    wr(cb(3, 8'h00), 32'd1);
    burst(6);
    rd(cb(3, 8'h0C), v);   chk("R4 full range no wrap", v, 0);
    rd(cb(3, 8'h08), v);   chk("R4 inverted count", ~v, 7);
    wr(cb(3, 8'h00), 32'd0);
  endtask

  task automatic t_ro();
    logic [31:0] v;
    wr(8'h00, 32'd1);
    rd(8'h00, v);          chk("R1 bank enable readback", v, 1);
    wr(8'h00, 32'd0);
    wr(8'h10, 32'hDEAD_BEEF);
    rd(8'h10, v);          chk("R1 revision", v, REV_EXP);
    rd(cb(3, 8'h0C), v);
    wr(cb(3, 8'h0C), 32'h55);
    wr(cb(3, 8'h08), 32'h55);
    rd(cb(3, 8'h08), v);   chk("R9 counter write ignored", v, 32'hFFFF_FFF8);
    rd(cb(3, 8'h0C), v);   chk("R9 wrap write ignored", v, 0);
    wr(cb(2, 8'h10), 32'd0);
    rd(cb(2, 8'h10), v);   chk("R9 status write ignored", v, 1);
    rd(8'h1C, v);          chk("R9 unmapped bank offset", v, 0);
    rd(8'h10, v);
    rd(cb(0, 8'h1C), v);   chk("R9 unmapped channel offset", v, 0);
    rd(8'h10, v);
    rd(8'hE0, v);          chk("R9 unmapped window", v, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_gate();
    t_snap();
    t_reenable();
    t_zero();
    t_free();
    t_ro();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule